// File: doc/BRIEF.md
# Receive Delimiter Search and Header Checker

This block sits on the receive path behind chip-level acquisition. It is fed descrambled bits, each qualified by a valid strobe. When the acquisition logic reports lock with a one-cycle pulse, the block opens a bounded search for the 16-bit start-of-frame delimiter. The size of the search window is set by a two-bit code. If the window closes without a match, the block emits a one-cycle request to go back to acquisition.

Once the delimiter is found, the block collects 48 header bits: an 8-bit rate code, an 8-bit service byte, a 16-bit length, and then a 16-bit check word. It runs a CRC over the first 32 bits and compares the complemented remainder with the received check word. When they agree, it presents the three fields, a demodulation-mode select derived from the rate code, and a data-ready flag. When they disagree, it sets a sticky error bit, keeps data-ready low and requests re-acquisition.

Top module: `rx_hdr_check`

## Requirements
- R1: A pulse on `acq_pulse` starts a delimiter search and samples `short_mode` and `tmo_sel` at that edge. In long mode the pattern is 16'hF3A0. In short mode it is the bit-reversed pattern 16'h05CF. The first bit received is compared with the pattern MSB.
- R2: `tmo_sel` codes 0, 1, 2 and 3 allow 16, 32, 64 and 128 valid bits, counted from the acquisition pulse. A match on the last allowed bit is accepted. Otherwise, that last bit raises `reacq` for exactly one cycle and the search ends.
- R3: No header is captured and `data_rdy` cannot rise unless the delimiter was found after the most recent acquisition pulse. Bits that arrive while no search is open are ignored.
- R4: After the delimiter, the header is 48 valid bits in this order: rate code (8 bits, LSB first), service (8 bits, LSB first), length (16 bits, LSB first), then the check word (16 bits, MSB first).
- R5: The CRC uses x^16+x^12+x^5+1, preset to all ones, and is fed the 32 field bits in arrival order. The header passes when the complemented remainder equals the received check word.
- R6: On a pass, `sig_fld`, `svc_fld`, `len_fld` and `demod_sel` update and `data_rdy` goes high after the clock edge that samples the last check bit. `data_rdy` stays high until the next acquisition pulse.
- R7: On a failure, `crc_err` is set, `data_rdy` stays low, `reacq` pulses for one cycle, the field outputs keep their previous values, and the block waits for a new acquisition pulse.
- R8: `crc_err` stays set until `err_clr` is high at a clock edge. A failure in the same cycle as `err_clr` leaves it set.
- R9: `demod_sel` maps rate code 8'h0A to 0, 8'h14 to 1, 8'h37 to 2 and 8'h6E to 3. Any other code maps to 0.
- R10: Cycles with `bit_vld` low have no effect on matching, timing or header capture.
- R11: An acquisition pulse at any time, including in the middle of a header, restarts the search and clears `data_rdy`.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Descrambled receive bit |
| bit_vld | input | 1 | Qualifies `bit_in` |
| acq_pulse | input | 1 | One-cycle acquisition-achieved pulse |
| short_mode | input | 1 | 1 selects the short (bit-reversed) delimiter |
| tmo_sel | input | 2 | Search window code |
| err_clr | input | 1 | Clears the sticky CRC error bit |
| sig_fld | output | 8 | Captured rate code |
| svc_fld | output | 8 | Captured service byte |
| len_fld | output | 16 | Captured length |
| demod_sel | output | 2 | Demodulation mode for the payload |
| data_rdy | output | 1 | Header valid, payload may follow |
| crc_err | output | 1 | Sticky header CRC failure |
| reacq | output | 1 | One-cycle request to return to acquisition |

## Verification
The bench drives the delimiter to end exactly on the last allowed bit and one bit after it, for the 16-bit and 32-bit windows. An off-by-one timer would either drop a good frame or accept a late one. Single-bit corruptions in the check word and in the rate code must both be caught. A design that compared the remainder without complementing it, or that fed the wrong bits into the CRC, would either flag good frames or pass bad ones. Further runs cover:
- strobe gaps carrying inverted garbage bits;
- a long delimiter presented in short mode;
- a mode change after the pulse;
- an acquisition pulse in the middle of a header;
- a full frame sent with no search open.

These catch designs that sample the mode live, or that keep stale shift-register contents across a restart.

// File: rtl/rx_hdr_pkg.sv
package rx_hdr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEARCH = 2'd1,
      ST_HDR    = 2'd2
   } hdr_st_t;

   typedef enum logic [1:0] {
      DM_DBPSK  = 2'd0,
      DM_DQPSK  = 2'd1,
      DM_CCK_LO = 2'd2,
      DM_CCK_HI = 2'd3
   } demod_t;

   localparam logic [7:0] RATE_1M  = 8'h0A;
   localparam logic [7:0] RATE_2M  = 8'h14;
   localparam logic [7:0] RATE_5M5 = 8'h37;
   localparam logic [7:0] RATE_11M = 8'h6E;

endpackage

// File: rtl/rx_hdr_delim.sv
module rx_hdr_delim #(
   parameter int             W        = 16,
   parameter logic [W-1:0]   LONG_PAT = 16'hF3A0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic shift_en,
   input  logic din,
   input  logic short_sel,
   output logic hit
);

   if (W < 2) begin : g_bad_w
      $error("rx_hdr_delim: W must be at least 2");
   end

   logic [W-1:0] win;
   logic [W-1:0] win_nxt;
   logic [W-1:0] rev_pat;
   logic [W-1:0] target;

   // short-mode pattern is the mirror image of the long one
   for (genvar i = 0; i < W; i++) begin : g_rev
      assign rev_pat[i] = LONG_PAT[W-1-i];
   end

   assign win_nxt = {win[W-2:0], din};
   assign target  = short_sel ? rev_pat : LONG_PAT;
   assign hit     = shift_en && (win_nxt == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win <= '0;
      end else if (clear) begin
         win <= '0;
      end else if (shift_en) begin
         win <= win_nxt;
      end
   end

endmodule

// File: rtl/rx_hdr_timer.sv
module rx_hdr_timer #(
   parameter int BASE  = 16,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [SEL_W-1:0] sel,
   input  logic             tick,
   output logic             expire
);

   localparam int MAX_LIM = BASE << ((1 << SEL_W) - 1);
   localparam int CW      = $clog2(MAX_LIM);

   if (BASE < 2 || (BASE & (BASE - 1)) != 0) begin : g_bad_base
      $error("rx_hdr_timer: BASE must be a power of two >= 2");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("rx_hdr_timer: SEL_W must be 1..3");
   end

   logic [SEL_W-1:0] sel_q;
   logic [CW-1:0]    cnt;
   logic [CW:0]      limit;
   logic [CW:0]      lim_m1;

   assign limit  = (CW+1)'(BASE) << sel_q;
   assign lim_m1 = limit - (CW+1)'(1);
   assign expire = tick && ({1'b0, cnt} == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sel_q <= '0;
      end else if (arm) begin
         cnt   <= '0;
         sel_q <= sel;
      end else if (tick && !expire) begin
         cnt <= cnt + 1'b1;
      end
   end

   // counted bits never reach the window size
   assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} < limit));

endmodule

// File: rtl/rx_hdr_crc16.sv
module rx_hdr_crc16 #(
   parameter int           W    = 16,
   parameter logic [W-1:0] POLY = 16'h1021
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc_q
);

   if (W < 2) begin : g_bad_w
      $error("rx_hdr_crc16: W must be at least 2");
   end

   logic         fb;
   logic [W-1:0] crc_nxt;

   assign fb      = crc_q[W-1] ^ din;
   assign crc_nxt = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '1;
      end else if (init) begin
         crc_q <= '1;
      end else if (en) begin
         crc_q <= crc_nxt;
      end
   end

endmodule

// File: rtl/rx_hdr_ratedec.sv
module rx_hdr_ratedec
   import rx_hdr_pkg::*;
(
   input  logic [7:0] rate,
   output demod_t     mode
);

   always_comb begin
      unique case (rate)
         RATE_2M:  mode = DM_DQPSK;
         RATE_5M5: mode = DM_CCK_LO;
         RATE_11M: mode = DM_CCK_HI;
         default:  mode = DM_DBPSK;
      endcase
   end

endmodule

// File: rtl/rx_hdr_check.sv
module rx_hdr_check
   import rx_hdr_pkg::*;
#(
   parameter int                 DELIM_W    = 16,
   parameter logic [DELIM_W-1:0] LONG_DELIM = 16'hF3A0,
   parameter int                 TMO_BASE   = 16,
   parameter int                 TMO_SEL_W  = 2,
   parameter int                 SIG_W      = 8,
   parameter int                 SVC_W      = 8,
   parameter int                 LEN_W      = 16,
   parameter int                 CRC_W      = 16,
   parameter logic [CRC_W-1:0]   CRC_POLY   = 16'h1021
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_in,
   input  logic                 bit_vld,
   input  logic                 acq_pulse,
   input  logic                 short_mode,
   input  logic [TMO_SEL_W-1:0] tmo_sel,
   input  logic                 err_clr,
   output logic [SIG_W-1:0]     sig_fld,
   output logic [SVC_W-1:0]     svc_fld,
   output logic [LEN_W-1:0]     len_fld,
   output logic [1:0]           demod_sel,
   output logic                 data_rdy,
   output logic                 crc_err,
   output logic                 reacq
);

   localparam int HDR_W = SIG_W + SVC_W + LEN_W;
   localparam int TOT_W = HDR_W + CRC_W;
   localparam int POS_W = $clog2(TOT_W);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(TOT_W - 1);
   localparam logic [POS_W-1:0] FLD_END  = POS_W'(HDR_W);

   if (SIG_W != 8) begin : g_bad_sig
      $error("rx_hdr_check: rate decoder expects an 8-bit rate code");
   end
   if (CRC_W < 2 || DELIM_W < 2) begin : g_bad_crc
      $error("rx_hdr_check: CRC_W and DELIM_W must be at least 2");
   end

   hdr_st_t          st;
   logic             short_q;
   logic [POS_W-1:0] pos;
   logic [HDR_W-1:0] hdr_sr;
   logic [CRC_W-1:0] rx_chk;
   logic [CRC_W-1:0] rx_chk_full;
   logic [CRC_W-1:0] crc_q;
   logic             srch_tick;
   logic             hdr_tick;
   logic             in_fields;
   logic             last_bit;
   logic             chk_ok;
   logic             hdr_fail;
   logic             delim_hit;
   logic             tmo_exp;
   demod_t           dec_mode;

   assign srch_tick   = bit_vld && !acq_pulse && (st == ST_SEARCH);
   assign hdr_tick    = bit_vld && !acq_pulse && (st == ST_HDR);
   assign in_fields   = (pos < FLD_END);
   assign last_bit    = hdr_tick && (pos == LAST_POS);
   assign rx_chk_full = {rx_chk[CRC_W-2:0], bit_in};
   assign chk_ok      = (~crc_q == rx_chk_full);
   assign hdr_fail    = last_bit && !chk_ok;

   rx_hdr_delim #(
      .W        (DELIM_W),
      .LONG_PAT (LONG_DELIM)
   ) u_delim (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (acq_pulse),
      .shift_en  (srch_tick),
      .din       (bit_in),
      .short_sel (short_q),
      .hit       (delim_hit)
   );

   rx_hdr_timer #(
      .BASE  (TMO_BASE),
      .SEL_W (TMO_SEL_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (acq_pulse),
      .sel    (tmo_sel),
      .tick   (srch_tick),
      .expire (tmo_exp)
   );

   rx_hdr_crc16 #(
      .W    (CRC_W),
      .POLY (CRC_POLY)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (delim_hit),
      .en    (hdr_tick && in_fields),
      .din   (bit_in),
      .crc_q (crc_q)
   );

   rx_hdr_ratedec u_ratedec (
      .rate (hdr_sr[SIG_W-1:0]),
      .mode (dec_mode)
   );

   // header bit capture: fields arrive LSB first, check word MSB first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_sr <= '0;
         rx_chk <= '0;
      end else if (hdr_tick) begin
         if (in_fields) begin
            hdr_sr <= {bit_in, hdr_sr[HDR_W-1:1]};
         end else begin
            rx_chk <= rx_chk_full;
         end
      end
   end

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         short_q   <= 1'b0;
         pos       <= '0;
         data_rdy  <= 1'b0;
         reacq     <= 1'b0;
         sig_fld   <= '0;
         svc_fld   <= '0;
         len_fld   <= '0;
         demod_sel <= '0;
      end else begin
         reacq <= 1'b0;
         if (acq_pulse) begin
            st       <= ST_SEARCH;
            short_q  <= short_mode;
            data_rdy <= 1'b0;
         end else begin
            unique case (st)
               ST_SEARCH: begin
                  if (delim_hit) begin
                     st  <= ST_HDR;
                     pos <= '0;
                  end else if (tmo_exp) begin
                     st    <= ST_IDLE;
                     reacq <= 1'b1;
                  end
               end
               ST_HDR: begin
                  if (hdr_tick) begin
                     pos <= pos + 1'b1;
                     if (last_bit) begin
                        st <= ST_IDLE;
                        if (chk_ok) begin
                           sig_fld   <= hdr_sr[SIG_W-1:0];
                           svc_fld   <= hdr_sr[SIG_W +: SVC_W];
                           len_fld   <= hdr_sr[SIG_W+SVC_W +: LEN_W];
                           demod_sel <= dec_mode;
                           data_rdy  <= 1'b1;
                        end else begin
                           data_rdy <= 1'b0;
                           reacq    <= 1'b1;
                        end
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   // sticky error: a new failure outranks the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_err <= 1'b0;
      end else if (hdr_fail) begin
         crc_err <= 1'b1;
      end else if (err_clr) begin
         crc_err <= 1'b0;
      end
   end

   assert_rdy_after_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_rdy) |-> $past(st == ST_HDR));

   assert_fail_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_fail |=> (reacq && crc_err && !data_rdy));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(crc_err) |-> $past(err_clr));

   assert_rdy_excl_reacq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_rdy && reacq));

   assert_reacq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reacq |=> !reacq);

   assert_acq_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acq_pulse |=> (!data_rdy && st == ST_SEARCH));

   assert_fields_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !data_rdy |-> $stable(sig_fld) || $rose(data_rdy));

endmodule

// File: tb/rx_hdr_check_bench.sv
`timescale 1ns/1ps
module rx_hdr_check_bench;

   localparam logic [15:0] LONG_D  = 16'hF3A0;
   localparam logic [15:0] SHORT_D = 16'h05CF;

   typedef struct packed {
      logic        sh;
      logic [1:0]  tmo;
      logic [7:0]  pre;
      logic [7:0]  sig;
      logic [7:0]  svc;
      logic [15:0] len;
      logic [5:0]  flip;   // 63 = no corruption
      logic        gap;
      logic [1:0]  outc;   // 0 pass, 1 crc fail, 2 timeout
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd3, 8'd60, 8'h0A, 8'h00, 16'h0100, 6'd63, 1'b0, 2'd0},
      '{1'b1, 2'd2, 8'd40, 8'h14, 8'h80, 16'h1234, 6'd63, 1'b0, 2'd0},
      '{1'b0, 2'd0, 8'd0,  8'h37, 8'h5A, 16'h00FF, 6'd63, 1'b0, 2'd0},
      '{1'b0, 2'd0, 8'd1,  8'h6E, 8'h00, 16'h0001, 6'd63, 1'b0, 2'd2},
      '{1'b1, 2'd1, 8'd16, 8'h6E, 8'hC3, 16'hABCD, 6'd63, 1'b1, 2'd0},
      '{1'b1, 2'd1, 8'd17, 8'h0A, 8'h00, 16'h0002, 6'd63, 1'b0, 2'd2},
      '{1'b0, 2'd3, 8'd20, 8'h6E, 8'h11, 16'h0005, 6'd40, 1'b0, 2'd1},
      '{1'b0, 2'd3, 8'd20, 8'h0A, 8'h22, 16'h0777, 6'd3,  1'b1, 2'd1},
      '{1'b0, 2'd2, 8'd10, 8'h55, 8'h33, 16'hFEDC, 6'd63, 1'b0, 2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_in = 1'b0;
   logic        bit_vld = 1'b0;
   logic        acq_pulse = 1'b0;
   logic        short_mode = 1'b0;
   logic [1:0]  tmo_sel = 2'd0;
   logic        err_clr = 1'b0;
   logic [7:0]  sig_fld;
   logic [7:0]  svc_fld;
   logic [15:0] len_fld;
   logic [1:0]  demod_sel;
   logic        data_rdy;
   logic        crc_err;
   logic        reacq;

   int n_chk = 0;
   int n_bad = 0;
   int reacq_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   always @(posedge clk) if (reacq) reacq_cnt <= reacq_cnt + 1;

   rx_hdr_check u_rx_hdr_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_in     (bit_in),
      .bit_vld    (bit_vld),
      .acq_pulse  (acq_pulse),
      .short_mode (short_mode),
      .tmo_sel    (tmo_sel),
      .err_clr    (err_clr),
      .sig_fld    (sig_fld),
      .svc_fld    (svc_fld),
      .len_fld    (len_fld),
      .demod_sel  (demod_sel),
      .data_rdy   (data_rdy),
      .crc_err    (crc_err),
      .reacq      (reacq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_of(input logic [31:0] bits);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < 32; i++) begin
         logic fb = c[15] ^ bits[i];
         c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
      return c;
   endfunction

   function automatic logic [1:0] mode_of(input logic [7:0] s);
      case (s)
         8'h14:   return 2'd1;
         8'h37:   return 2'd2;
         8'h6E:   return 2'd3;
         default: return 2'd0;
      endcase
   endfunction

   task automatic send_bit(input logic b, input logic gap);
      bit_in  = b;
      bit_vld = 1'b1;
      @(negedge clk);
      bit_vld = 1'b0;
      if (gap) begin
         bit_in = ~b;   // garbage while the strobe is low (R10)
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic pulse_acq(input logic sh, input logic [1:0] tmo);
      short_mode = sh;
      tmo_sel    = tmo;
      acq_pulse  = 1'b1;
      @(negedge clk);
      acq_pulse  = 1'b0;
   endtask

   task automatic pulse_clr();
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   task automatic send_delim(input logic sh, input int pre, input logic gap);
      logic [15:0] pat = sh ? SHORT_D : LONG_D;
      for (int i = 0; i < pre; i++) send_bit(~sh, gap);
      for (int k = 15; k >= 0; k--) send_bit(pat[k], gap);
   endtask

   task automatic send_frame(input logic sh, input int pre, input logic [7:0] s,
                             input logic [7:0] v, input logic [15:0] l,
                             input int flip, input logic gap);
      logic [47:0] hb;
      logic [15:0] c;
      hb[31:0] = {l, v, s};            // index = arrival order, LSB first
      c = ~crc_of(hb[31:0]);
      for (int k = 0; k < 16; k++) hb[32+k] = c[15-k];
      if (flip < 48) hb[flip] = ~hb[flip];
      send_delim(sh, pre, gap);
      for (int i = 0; i < 48; i++) send_bit(hb[i], gap);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]  last_sig = 8'h00;
      logic [7:0]  last_svc = 8'h00;
      logic [15:0] last_len = 16'h0000;
      logic [1:0]  last_mode = 2'd0;
      int r0;

      repeat (3) @(negedge clk);
      // R12: reset values
      chk("R12", "sig", sig_fld, 0);
      chk("R12", "len", len_fld, 0);
      chk("R12", "flags", {data_rdy, crc_err, reacq, demod_sel}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R1 R2 R4 R5 R6 R7 R9 R10
      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         pulse_clr();
         r0 = reacq_cnt;
         pulse_acq(t.sh, t.tmo);
         send_frame(t.sh, int'(t.pre), t.sig, t.svc, t.len, int'(t.flip), t.gap);
         repeat (2) @(negedge clk);
         if (t.outc == 2'd0) begin
            last_sig = t.sig; last_svc = t.svc; last_len = t.len;
            last_mode = mode_of(t.sig);
         end
         chk(t.outc == 2'd2 ? "R2" : "R6", "data_rdy", data_rdy, t.outc == 2'd0);
         chk("R7", "crc_err", crc_err, t.outc == 2'd1);
         chk("R2", "reacq pulses", reacq_cnt - r0, t.outc != 2'd0);
         chk("R4", "sig", sig_fld, last_sig);
         chk("R4", "svc", svc_fld, last_svc);
         chk("R4", "len", len_fld, last_len);
         chk("R9", "demod_sel", demod_sel, last_mode);
      end

      // R8: error survives a later good frame, then clears
      pulse_acq(1'b0, 2'd3);
      send_frame(1'b0, 8, 8'h0A, 8'h00, 16'h0010, 45, 1'b0);
      repeat (2) @(negedge clk);
      chk("R8", "err set", crc_err, 1);
      pulse_acq(1'b0, 2'd3);
      send_frame(1'b0, 8, 8'h14, 8'h01, 16'h0020, 63, 1'b0);
      repeat (2) @(negedge clk);
      chk("R8", "err held", crc_err, 1);
      chk("R6", "rdy after pass", data_rdy, 1);
      pulse_clr();
      chk("R8", "err cleared", crc_err, 0);
      last_sig = 8'h14; last_svc = 8'h01; last_len = 16'h0020; last_mode = 2'd1;

      // R11: acquisition pulse mid-header restarts and drops data_rdy
      pulse_acq(1'b0, 2'd3);
      chk("R11", "rdy cleared", data_rdy, 0);
      send_delim(1'b0, 4, 1'b0);
      for (int i = 0; i < 10; i++) send_bit(i[0], 1'b0);
      pulse_acq(1'b0, 2'd3);
      send_frame(1'b0, 3, 8'h37, 8'h44, 16'h4321, 63, 1'b0);
      repeat (2) @(negedge clk);
      chk("R11", "restart rdy", data_rdy, 1);
      chk("R11", "restart len", len_fld, 16'h4321);

      // R1: long delimiter in short mode never matches -> timeout
      r0 = reacq_cnt;
      pulse_acq(1'b1, 2'd3);
      send_frame(1'b0, 120, 8'h0A, 8'h00, 16'h0001, 63, 1'b0);
      repeat (2) @(negedge clk);
      chk("R1", "mode mismatch rdy", data_rdy, 0);
      chk("R1", "mode mismatch reacq", reacq_cnt - r0, 1);

      // R3: frame with no search open is ignored
      r0 = reacq_cnt;
      send_frame(1'b0, 2, 8'h6E, 8'h99, 16'h0BAD, 63, 1'b0);
      repeat (2) @(negedge clk);
      chk("R3", "no search rdy", data_rdy, 0);
      chk("R3", "no search len", len_fld, 16'h4321);
      chk("R3", "no search reacq", reacq_cnt - r0, 0);

      // R1: mode sampled at the pulse, later changes ignored
      pulse_acq(1'b0, 2'd2);
      short_mode = 1'b1;
      send_frame(1'b0, 5, 8'h14, 8'h00, 16'h0042, 63, 1'b0);
      repeat (2) @(negedge clk);
      chk("R1", "latched mode rdy", data_rdy, 1);
      chk("R1", "latched mode len", len_fld, 16'h0042);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule